// File: doc/BRIEF.md
# Byte-Wide Flash Command Interface

This block models a byte-wide non-volatile memory whose bus writes are commands rather than plain data. A synchronous slave port carries a write strobe, a read strobe, a byte address, write data and read data. A command state machine decides what each write means, and it keeps the current read mode, a two-cycle handshake counter and a status register. The read mode steers each read to the storage array, the status register or a 16-bit device identifier.

Programming a byte and erasing a block each take two bus writes. An erase sweeps the addressed block back to all ones at one byte per clock. A busy output is raised while the sweep runs, and every bus write is ignored during that time. Parameters set the array size, the erase block size, the address width and the identifier. The array size must be a multiple of the block size, and the address width must be wide enough to name addresses beyond the array.

Top module: `bflash_top`

## Requirements
- R1: After reset the block is in array read mode with status 0x00, no two-cycle command pending, `busy` low, `rdData` at 0x00, and every array byte at 0xFF.
- R2: A first-cycle write of 0xFF selects array reads, 0x70 selects status reads, 0x90 selects identifier reads, and 0xB0 selects a blank mode in which reads return 0xFF. The address of any first-cycle write is ignored.
- R3: A first-cycle write of 0x50 clears the whole status register to 0x00 and returns the block to array read mode.
- R4: A first-cycle write of 0x40 or 0x10 arms a program, and the mode becomes blank. The next write stores its data byte at its address when that address is below the array size. A write to an address outside the array is dropped. Either way the handshake then ends.
- R5: A first-cycle write of 0x20 arms an erase. When the next write carries 0xD0, the block holding its address is set to 0xFF one byte per clock. The block base is the address with its low log2(block size) bits cleared. `busy` is high for exactly block-size cycles, starting on the clock that takes the confirm write. A confirm at an address outside the array erases nothing and does not raise `busy`.
- R6: When the write after 0x20 carries any byte other than 0xD0, no byte is erased, the block enters status read mode, and status bits 5 (erase error) and 4 (program error) are set. Other status bits are not cleared.
- R7: In array mode a read returns the stored byte, or 0xFF when the address is outside the array. In status mode it returns the status register. In identifier mode it returns the high identifier byte when address bit 0 is 1 and the low byte when it is 0. In blank mode it returns 0xFF.
- R8: A first-cycle write of any byte that is not a recognised command changes neither the mode, the status nor the handshake state.
- R9: While `busy` is high, every bus write is ignored.
- R10: Read data appears on `rdData` one clock after the read strobe and holds until the next read. A read never changes the mode or the status. A read and a write in the same cycle see the mode and array contents from before that write.
- R11: Only status bits 5 and 4 can ever become set. Bits 7, 6 and 3 through 0 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Bus write strobe (command or command data) |
| rdEn | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Byte address for reads and writes |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Read data, valid the clock after `rdEn` |
| busy | output | 1 | High while a block erase sweep is running |

## Verification
A read strobe and a command write can land in the same cycle. The read must then return data chosen by the mode that was in force before the write. The bench provokes this by pulsing both strobes together in array mode, with a status-read command on the write bus. It expects the stored array byte from that read and the status byte from the next read. The erase sweep and an incoming bus write can also overlap. The bench sends an identifier command in the middle of the sweep, then confirms that the sweep length is unchanged and that a read after the sweep still returns blank 0xFF rather than an identifier byte.

// File: rtl/bflash_pkg.sv
package bflash_pkg;

  // Read source selected by the command history
  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_STATUS = 2'd1,
    SRC_ID     = 2'd2,
    SRC_BLANK  = 2'd3
  } rdSrc_e;

  // Strobes and state passed from control to datapath
  typedef struct packed {
    logic        progWr;
    logic        eraseGo;
    rdSrc_e      rdSrc;
    logic [7:0]  status;
  } dpCtl_t;

  // Command byte values
  localparam logic [7:0] OP_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] OP_READ_STATUS = 8'h70;
  localparam logic [7:0] OP_READ_ID     = 8'h90;
  localparam logic [7:0] OP_CLR_STATUS  = 8'h50;
  localparam logic [7:0] OP_SUSPEND     = 8'hB0;
  localparam logic [7:0] OP_PROG_A      = 8'h40;
  localparam logic [7:0] OP_PROG_B      = 8'h10;
  localparam logic [7:0] OP_ERASE_ARM   = 8'h20;
  localparam logic [7:0] OP_ERASE_OK    = 8'hD0;

  // Status bits raised by a failed erase handshake
  localparam int         ST_ERASE_ERR_BIT = 5;
  localparam int         ST_PROG_ERR_BIT  = 4;
  localparam logic [7:0] ST_FAIL_MASK     = (8'h1 << ST_ERASE_ERR_BIT) | (8'h1 << ST_PROG_ERR_BIT);

endpackage

// File: rtl/bflash_ctrl.sv
module bflash_ctrl
  import bflash_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int ARRAY_BYTES = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              busy,
  output dpCtl_t            ctl,
  output logic              pending
);

  localparam logic [ADDR_W-1:0] ARRAY_LIMIT = ADDR_W'(ARRAY_BYTES);

  rdSrc_e     mode;
  logic       pendErase;
  logic [7:0] status;
  logic       takeWr;
  logic       inArray;
  logic       confirmOk;

  assign takeWr    = wrEn && !busy;
  assign inArray   = addr < ARRAY_LIMIT;
  assign confirmOk = wrData == OP_ERASE_OK;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode      <= SRC_ARRAY;
      pending   <= 1'b0;
      pendErase <= 1'b0;
      status    <= 8'h00;
    end else if (takeWr) begin
      if (!pending) begin
        // First cycle: only the data byte matters
        case (wrData)
          OP_READ_ARRAY:  mode <= SRC_ARRAY;
          OP_READ_STATUS: mode <= SRC_STATUS;
          OP_READ_ID:     mode <= SRC_ID;
          OP_SUSPEND:     mode <= SRC_BLANK;
          OP_CLR_STATUS: begin
            status <= 8'h00;
            mode   <= SRC_ARRAY;
          end
          OP_PROG_A, OP_PROG_B: begin
            mode      <= SRC_BLANK;
            pending   <= 1'b1;
            pendErase <= 1'b0;
          end
          OP_ERASE_ARM: begin
            mode      <= SRC_BLANK;
            pending   <= 1'b1;
            pendErase <= 1'b1;
          end
          default: ;
        endcase
      end else begin
        // Second cycle closes the handshake
        pending <= 1'b0;
        if (pendErase && !confirmOk) begin
          mode   <= SRC_STATUS;
          status <= status | ST_FAIL_MASK;
        end
      end
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.progWr  = takeWr && pending && !pendErase && inArray;
    ctl.eraseGo = takeWr && pending && pendErase && confirmOk && inArray;
    ctl.rdSrc   = mode;
    ctl.status  = status;
  end

endmodule

// File: rtl/bflash_sweep.sv
module bflash_sweep #(
  parameter int IDX_W       = 8,
  parameter int BLOCK_BYTES = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [IDX_W-1:0] blockBase,
  output logic             active,
  output logic [IDX_W-1:0] sweepIdx
);

  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(BLOCK_BYTES - 1);

  logic [IDX_W-1:0] base;
  logic [OFF_W-1:0] off;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      base   <= '0;
      off    <= '0;
    end else if (start) begin
      active <= 1'b1;
      base   <= blockBase;
      off    <= '0;
    end else if (active) begin
      off <= off + 1'b1;
      if (off == LAST_OFF) active <= 1'b0;
    end
  end

  // base is block aligned, so OR-ing the offset forms the byte index
  assign sweepIdx = base | IDX_W'(off);

endmodule

// File: rtl/bflash_datapath.sv
module bflash_datapath
  import bflash_pkg::*;
#(
  parameter int          ADDR_W      = 10,
  parameter int          ARRAY_BYTES = 256,
  parameter int          BLOCK_BYTES = 32,
  parameter logic [15:0] DEV_ID      = 16'hA2B1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              busy
);

  localparam int IDX_W = $clog2(ARRAY_BYTES);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam logic [ADDR_W-1:0] ARRAY_LIMIT = ADDR_W'(ARRAY_BYTES);

  logic [7:0]       mem [ARRAY_BYTES];
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] blockBase;
  logic [IDX_W-1:0] sweepIdx;
  logic             sweepOn;
  logic             inArray;
  logic [7:0]       arrayByte;
  logic [7:0]       idByte;
  logic [7:0]       rdNext;

  assign idx       = addr[IDX_W-1:0];
  assign inArray   = addr < ARRAY_LIMIT;
  assign blockBase = {idx[IDX_W-1:OFF_W], {OFF_W{1'b0}}};

  bflash_sweep #(
    .IDX_W      (IDX_W),
    .BLOCK_BYTES(BLOCK_BYTES)
  ) u_sweep (
    .clk      (clk),
    .rstN     (rstN),
    .start    (ctl.eraseGo),
    .blockBase(blockBase),
    .active   (sweepOn),
    .sweepIdx (sweepIdx)
  );

  assign busy = sweepOn;

  // Storage: programs never overlap a sweep (control blocks writes while busy)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ARRAY_BYTES; i++) mem[i] <= 8'hFF;
    end else begin
      if (sweepOn) mem[sweepIdx] <= 8'hFF;
      if (ctl.progWr) mem[idx] <= wrData;
    end
  end

  assign arrayByte = inArray ? mem[idx] : 8'hFF;
  assign idByte    = addr[0] ? DEV_ID[15:8] : DEV_ID[7:0];

  always_comb begin
    case (ctl.rdSrc)
      SRC_ARRAY:  rdNext = arrayByte;
      SRC_STATUS: rdNext = ctl.status;
      SRC_ID:     rdNext = idByte;
      default:    rdNext = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)     rdData <= 8'h00;
    else if (rdEn) rdData <= rdNext;
  end

endmodule

// File: rtl/bflash_top.sv
module bflash_top
  import bflash_pkg::*;
#(
  parameter int          ADDR_W      = 10,
  parameter int          ARRAY_BYTES = 256,
  parameter int          BLOCK_BYTES = 32,
  parameter logic [15:0] DEV_ID      = 16'hA2B1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              busy
);

  dpCtl_t dpCtl;
  logic   cmdPending;

  bflash_ctrl #(
    .ADDR_W     (ADDR_W),
    .ARRAY_BYTES(ARRAY_BYTES)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .busy   (busy),
    .ctl    (dpCtl),
    .pending(cmdPending)
  );

  bflash_datapath #(
    .ADDR_W     (ADDR_W),
    .ARRAY_BYTES(ARRAY_BYTES),
    .BLOCK_BYTES(BLOCK_BYTES),
    .DEV_ID     (DEV_ID)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (dpCtl),
    .rdEn  (rdEn),
    .addr  (addr),
    .wrData(wrData),
    .rdData(rdData),
    .busy  (busy)
  );

endmodule

// File: rtl/bflash_checker.sv
module bflash_checker
  import bflash_pkg::*;
#(
  parameter int BLOCK_BYTES = 32
) (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       rdEn,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic       busy,
  input dpCtl_t     ctl,
  input logic       pending
);

  int busyRun;

  always_ff @(posedge clk) begin
    if (!rstN)     busyRun <= 0;
    else if (busy) busyRun <= busyRun + 1;
    else           busyRun <= 0;
  end

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  assert_rd_no_effect_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && !busy) |=> ($stable(ctl.status) && $stable(ctl.rdSrc)));

  assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyRun < BLOCK_BYTES));

  assert_erase_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.eraseGo |=> busy);

  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(ctl.progWr || ctl.eraseGo));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !busy && !pending && wrData == OP_CLR_STATUS) |=> (ctl.status == 8'h00 && ctl.rdSrc == SRC_ARRAY));

  assert_handshake_ends_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pending && wrEn && !busy) |=> !pending);

  assert_status_bits_R11: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.status & ~ST_FAIL_MASK) == 8'h00);

endmodule

bind bflash_top bflash_checker #(.BLOCK_BYTES(BLOCK_BYTES)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .rdEn   (rdEn),
  .wrData (wrData),
  .rdData (rdData),
  .busy   (busy),
  .ctl    (dpCtl),
  .pending(cmdPending)
);

// File: tb/tb_bflash_top.sv
module tb_bflash_top;

  localparam int          ADDR_W      = 10;
  localparam int          ARRAY_BYTES = 256;
  localparam int          BLOCK_BYTES = 32;
  localparam logic [15:0] DEV_ID      = 16'hA2B1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic              rdEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        wrData = 8'h00;
  logic [7:0]        rdData;
  logic              busy;

  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;
  logic sawRd = 1'b0;

  logic [7:0] expQ[$];
  string      tagQ[$];

  always #4 clk = ~clk;

  bflash_top #(
    .ADDR_W     (ADDR_W),
    .ARRAY_BYTES(ARRAY_BYTES),
    .BLOCK_BYTES(BLOCK_BYTES),
    .DEV_ID     (DEV_ID)
  ) dut (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .addr  (addr),
    .wrData(wrData),
    .rdData(rdData),
    .busy  (busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: a read strobe seen at an edge yields data at the following negedge
  always @(posedge clk) sawRd <= rdEn;

  always @(negedge clk) begin
    if (sawRd) begin
      if (expQ.size() == 0) begin
        check(1'b0, "scoreboard underflow", rdData, 0);
      end else begin
        automatic logic [7:0] e = expQ.pop_front();
        automatic string      t = tagQ.pop_front();
        check(rdData == e, t, rdData, e);
      end
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    expQ.push_back(e); tagQ.push_back(t);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic rdwr(input logic [ADDR_W-1:0] a, input logic [7:0] d, input logic [7:0] e, input string t);
    @(negedge clk);
    rdEn = 1'b1; wrEn = 1'b1; addr = a; wrData = d;
    expQ.push_back(e); tagQ.push_back(t);
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      check(1'b0, "watchdog expired", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check(rdData == 8'h00, "R1 rdData after reset", rdData, 8'h00);
    rd(10'h005, 8'hFF, "R1 erased array after reset");
    rd(10'h0FF, 8'hFF, "R1 last byte erased");

    // Program with 0x40, first-cycle address ignored
    wr(10'h3FF, 8'h40);
    rd(10'h005, 8'hFF, "R7 blank read while program armed");
    wr(10'h005, 8'h5A);
    wr(10'h123, 8'hFF);
    rd(10'h005, 8'h5A, "R4 program 0x40 stored");
    rd(10'h006, 8'hFF, "R4 neighbour untouched");

    // Alternate program code
    wr(10'h000, 8'h10);
    wr(10'h021, 8'hC3);
    wr(10'h000, 8'hFF);
    rd(10'h021, 8'hC3, "R4 program 0x10 stored");

    // Program outside the array is dropped
    wr(10'h000, 8'h40);
    wr(10'h200, 8'h11);
    wr(10'h000, 8'hFF);
    rd(10'h200, 8'hFF, "R7 out-of-range array read");
    rd(10'h000, 8'hFF, "R4 out-of-range program dropped");

    // Identifier reads
    wr(10'h2AA, 8'h90);
    rd(10'h000, DEV_ID[7:0],  "R7 ID low byte at even address");
    rd(10'h001, DEV_ID[15:8], "R7 ID high byte at odd address");
    rd(10'h3FF, DEV_ID[15:8], "R2 ID mode from command at any address");

    // Status reads
    wr(10'h155, 8'h70);
    rd(10'h000, 8'h00, "R2 status mode reads zero status");

    // Failed erase handshake
    wr(10'h000, 8'h20);
    wr(10'h040, 8'h77);
    rd(10'h000, 8'h30, "R6 bad confirm sets error bits");
    rd(10'h000, 8'h30, "R10 repeated read leaves status");
    wr(10'h000, 8'h33);
    rd(10'h000, 8'h30, "R8 unknown byte keeps status mode");
    wr(10'h000, 8'hFF);
    rd(10'h005, 8'h5A, "R6 no erase on bad confirm");
    wr(10'h000, 8'h20);
    wr(10'h000, 8'h00);
    rd(10'h000, 8'h30, "R11 status holds only bits 5 and 4");

    // Clear status
    wr(10'h000, 8'h50);
    rd(10'h005, 8'h5A, "R3 clear returns to array mode");
    wr(10'h000, 8'h70);
    rd(10'h000, 8'h00, "R3 status cleared");

    // Suspend code gives blank reads
    wr(10'h000, 8'hB0);
    rd(10'h005, 8'hFF, "R2 suspend mode reads blank");
    wr(10'h000, 8'hFF);

    // Prepare block 1 and block 2 contents
    wr(10'h000, 8'h40); wr(10'h025, 8'h99);
    wr(10'h000, 8'h40); wr(10'h040, 8'h66);
    wr(10'h000, 8'hFF);
    rd(10'h025, 8'h99, "R4 second program stored");

    // Erase block 1 via an address inside it
    wr(10'h000, 8'h20);
    wr(10'h02E, 8'hD0);
    check(busy == 1'b1, "R5 busy after confirm", busy, 1);
    wr(10'h001, 8'h90);
    cnt = 2;
    while (busy && cnt < 200) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt == BLOCK_BYTES, "R5 busy length", cnt, BLOCK_BYTES);
    rd(10'h001, 8'hFF, "R9 write during busy ignored");
    wr(10'h000, 8'hFF);
    rd(10'h021, 8'hFF, "R5 erased byte 0x21");
    rd(10'h025, 8'hFF, "R5 erased byte 0x25");
    rd(10'h03F, 8'hFF, "R5 erased top of block");
    rd(10'h005, 8'h5A, "R5 lower block untouched");
    rd(10'h040, 8'h66, "R5 upper block untouched");

    // Erase at an out-of-range address
    wr(10'h000, 8'h20);
    wr(10'h300, 8'hD0);
    check(busy == 1'b0, "R5 out-of-range erase no busy", busy, 0);
    wr(10'h000, 8'hFF);
    rd(10'h040, 8'h66, "R5 out-of-range erase leaves array");

    // Same-cycle read and command write
    rdwr(10'h005, 8'h70, 8'h5A, "R10 same-cycle read uses old mode");
    rd(10'h005, 8'h00, "R10 command took effect after read");
    repeat (3) @(negedge clk);
    check(rdData == 8'h00, "R10 rdData holds without read", rdData, 8'h00);

    // Same-cycle read and program of the same byte
    wr(10'h000, 8'hFF);
    wr(10'h000, 8'h40);
    wr(10'h000, 8'hFF);
    wr(10'h000, 8'h40);
    rdwr(10'h007, 8'hAB, 8'hFF, "R10 read beside program sees blank mode");
    wr(10'h000, 8'hFF);
    rd(10'h007, 8'hAB, "R4 program after same-cycle read");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);
    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end

endmodule